// File: doc/BRIEF.md
# Instruction Pointer Table Identifier

This block sits beside the instruction fetcher of a variable-length instruction set machine. Each cycle the fetcher presents a fetch address, and the block answers in the same cycle with a group of up to N instruction start addresses, each with its own valid flag, and the address it expects to be fetched next. To do this it keeps a small table of recorded pointer sequences. An entry holds a base address and N fields. Each field holds a 4-bit byte displacement from the base, a known-length flag and a line-crossing flag. A separate end displacement marks where the last recorded instruction finishes.

If the fetch address matches a recorded base, the recorded pointers come out at once. If it misses, or the entry is not yet full, the first instruction of unknown length is guessed to be 3 bytes long. This guessed instruction is called the probe. The instruction right after it is called the follower. Two external length sizers supply the real lengths of the probe and the follower in the same cycle. The follower is released only when the guess was right. Confirmed pointers are then written back, either appended to the entry used in the previous cycle or placed in a newly allocated entry, with FIFO replacement.

Top module: `ipt_ident`

## Requirements
- R1: While fetch_vld_i is low, ptr_vld_o is 0, hit_o is 0 and the table is left unchanged.
- R2: When the fetch address equals the base of a full entry, hit_o is 1 and slots 0..N-1 carry base+offset of each recorded field in field order. No length is guessed, and the next address is the base plus the end displacement.
- R3: On a miss, slot 0 is the fetch address (the probe). Slot 1 is the fetch address plus 3, and it is valid only when the probe's real length equals 3.
- R4: On a hit to a partly filled entry with c recorded fields, slots 0..c-1 carry the recorded pointers. Slot c carries the probe at base plus end displacement. Slot c+1, if it exists, carries the follower at probe plus 3 under the rule of R3.
- R5: nsfa_o is the start of the last valid slot plus that instruction's real length. For recorded slots this is the next recorded pointer or the entry end. For the probe it is the probe length. For the follower it is the follower length.
- R6: Bit k of taken_i marks slot k as a taken branch. Slot k is still output, later slots are dropped, and valid flags always form a contiguous run from slot 0.
- R7: On a miss whose address equals the previous cycle's nsfa_o and the end of the entry used in that cycle, when that entry has a free field and the new displacements fit, the confirmed pointers are appended to that entry's next free fields.
- R8: On any other miss a new entry is allocated at the FIFO position, with base equal to the fetch address. This covers a miss that differs from the previous nsfa_o and a miss whose previous entry has no free field.
- R9: A miss with split_i high always allocates a new entry, even when the append conditions of R7 hold.
- R10: Displacements are 4 bits wide. A confirmed instruction whose end would exceed 15 bytes from the base is not recorded. A probe that does not fit on a hit leaves the entry unchanged.
- R11: The table holds DEPTH entries (64 by default) and allocation overwrites them in FIFO order, starting from entry 0 after reset.
- R12: Reset clears every known-length flag, so all addresses miss afterwards.
- R13: ptr_spl_o[k] is high when slot k is valid and is marked as crossing a line. Recorded slots take the stored flag, and the probe on a miss takes split_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_vld_i | input | 1 | Fetch address is valid this cycle |
| fetch_pc_i | input | AW | Fetch address |
| split_i | input | 1 | Instruction at the fetch address crosses a line |
| taken_i | input | N | Per-slot taken-branch marks |
| len_p_i | input | 4 | Real length of the probe instruction |
| len_s_i | input | 4 | Real length of the follower instruction |
| hit_o | output | 1 | Fetch address matched a recorded base |
| ptr_vld_o | output | N | Per-slot valid flags |
| ptr_spl_o | output | N | Per-slot line-crossing flags |
| ptr_o | output | N*AW | Slot start addresses, slot 0 in the low bits |
| nsfa_o | output | AW | Next sequential fetch address |

## Verification
A corrupted offset or end displacement does not show when it is written. It shows the next time that base is fetched, as a wrong pointer in a recorded slot, as a probe at the wrong address, or as a wrong nsfa_o, all in that same cycle. A lost append or a wrong allocation shows as hit_o flipping, or as the recorded run being shorter or longer than expected on a later fetch. A wrong FIFO pointer shows only after a full wrap, when a stale entry either survives or disappears one allocation too early. The sequence therefore revisits each base after writing it, and it runs the FIFO through a complete cycle.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int OFS_W     = 4;
  localparam int LEN_W     = 4;
  localparam int GUESS_LEN = 3;

  typedef struct packed {
    logic             vld;
    logic             spl;
    logic [OFS_W-1:0] ofs;
  } ipt_fld_t;
endpackage

// File: rtl/ipt_table.sv
module ipt_table
  import ipt_pkg::*;
#(
  parameter int N     = 4,
  parameter int DEPTH = 64,
  parameter int AW    = 32,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(N + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [AW-1:0]             lk_pc_i,
  output logic                      lk_hit_o,
  output logic [IW-1:0]             lk_idx_o,
  output logic [AW-1:0]             lk_base_o,
  output logic [N-1:0][OFS_W-1:0]   lk_ofs_o,
  output logic [N-1:0]              lk_spl_o,
  output logic [CW-1:0]             lk_cnt_o,
  output logic [OFS_W-1:0]          lk_tail_o,
  input  logic [IW-1:0]             rd_idx_i,
  output logic [AW-1:0]             rd_base_o,
  output logic [CW-1:0]             rd_cnt_o,
  output logic [OFS_W-1:0]          rd_tail_o,
  input  logic                      wr_en_i,
  input  logic                      wr_clr_i,
  input  logic [IW-1:0]             wr_idx_i,
  input  logic [AW-1:0]             wr_base_i,
  input  logic [CW-1:0]             wr_slot_i,
  input  logic                      wr_two_i,
  input  logic [OFS_W-1:0]          wr_ofs0_i,
  input  logic [OFS_W-1:0]          wr_ofs1_i,
  input  logic                      wr_spl_i,
  input  logic [OFS_W-1:0]          wr_tail_i
);
  ipt_fld_t         fld_q  [DEPTH][N];
  logic [AW-1:0]    base_q [DEPTH];
  logic [OFS_W-1:0] tail_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++)
        for (int k = 0; k < N; k++) fld_q[e][k] <= '0;
    end else if (wr_en_i) begin
      for (int k = 0; k < N; k++) begin
        if (wr_clr_i) fld_q[wr_idx_i][k] <= '0;
        if (k == int'(wr_slot_i)) fld_q[wr_idx_i][k] <= '{1'b1, wr_spl_i, wr_ofs0_i};
        if (wr_two_i && k == int'(wr_slot_i) + 1) fld_q[wr_idx_i][k] <= '{1'b1, 1'b0, wr_ofs1_i};
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      if (wr_clr_i) base_q[wr_idx_i] <= wr_base_i;
      tail_q[wr_idx_i] <= wr_tail_i;
    end
  end

  // base match on entries whose first field is known
  always_comb begin
    lk_hit_o = 1'b0;
    lk_idx_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (fld_q[e][0].vld && base_q[e] == lk_pc_i) begin
        lk_hit_o = 1'b1;
        lk_idx_o = IW'(e);
      end
    end
  end

  always_comb begin
    lk_base_o = base_q[lk_idx_o];
    lk_tail_o = tail_q[lk_idx_o];
    lk_cnt_o  = '0;
    for (int k = 0; k < N; k++) begin
      lk_ofs_o[k] = fld_q[lk_idx_o][k].ofs;
      lk_spl_o[k] = fld_q[lk_idx_o][k].spl;
      lk_cnt_o    = lk_cnt_o + CW'(fld_q[lk_idx_o][k].vld);
    end
  end

  always_comb begin
    rd_base_o = base_q[rd_idx_i];
    rd_tail_o = tail_q[rd_idx_i];
    rd_cnt_o  = '0;
    for (int k = 0; k < N; k++) rd_cnt_o = rd_cnt_o + CW'(fld_q[rd_idx_i][k].vld);
  end
endmodule

// File: rtl/ipt_group.sv
module ipt_group
  import ipt_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int CW = $clog2(N + 1)
) (
  input  logic                    fetch_vld_i,
  input  logic [AW-1:0]           pc_i,
  input  logic                    split_i,
  input  logic [N-1:0]            taken_i,
  input  logic [LEN_W-1:0]        len_p_i,
  input  logic [LEN_W-1:0]        len_s_i,
  input  logic                    hit_i,
  input  logic [AW-1:0]           base_i,
  input  logic [N-1:0][OFS_W-1:0] ofs_i,
  input  logic [N-1:0]            spl_i,
  input  logic [CW-1:0]           cnt_i,
  input  logic [OFS_W-1:0]        tail_i,
  output logic [N-1:0][AW-1:0]    ptr_o,
  output logic [N-1:0]            vld_o,
  output logic [N-1:0]            spl_o,
  output logic [AW-1:0]           nsfa_o,
  output logic                    p_out_o,
  output logic                    s_out_o
);
  logic [CW-1:0] c;
  logic [AW-1:0] u;

  always_comb begin
    logic          live, ok, sp;
    logic [AW-1:0] p, nx;
    c       = hit_i ? cnt_i : '0;
    u       = hit_i ? base_i + AW'(tail_i) : pc_i;
    live    = fetch_vld_i;
    nsfa_o  = pc_i;
    p_out_o = 1'b0;
    s_out_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      ok = 1'b0; sp = 1'b0; p = u; nx = u;
      if (k < int'(c)) begin
        ok = 1'b1;
        p  = base_i + AW'(ofs_i[k]);
        sp = spl_i[k];
        nx = (k + 1 < int'(c)) ? base_i + AW'(ofs_i[(k+1)%N]) : base_i + AW'(tail_i);
      end else if (k == int'(c)) begin
        ok = 1'b1;
        nx = u + AW'(len_p_i);
        sp = ~hit_i & split_i;
      end else if (k == int'(c) + 1) begin
        ok = (len_p_i == LEN_W'(GUESS_LEN));
        p  = u + AW'(GUESS_LEN);
        nx = p + AW'(len_s_i);
      end
      vld_o[k] = live & ok;
      ptr_o[k] = p;
      spl_o[k] = vld_o[k] & sp;
      if (vld_o[k]) nsfa_o = nx;
      if (k == int'(c)) p_out_o = vld_o[k];
      if (k == int'(c) + 1) s_out_o = vld_o[k];
      live = vld_o[k] & ~taken_i[k];
    end
  end
endmodule

// File: rtl/ipt_place.sv
module ipt_place
  import ipt_pkg::*;
#(
  parameter int N     = 4,
  parameter int DEPTH = 64,
  parameter int AW    = 32,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_vld_i,
  input  logic [AW-1:0]    pc_i,
  input  logic             split_i,
  input  logic [LEN_W-1:0] len_p_i,
  input  logic [LEN_W-1:0] len_s_i,
  input  logic             hit_i,
  input  logic [IW-1:0]    hit_idx_i,
  input  logic [CW-1:0]    hcnt_i,
  input  logic [OFS_W-1:0] htail_i,
  input  logic             p_out_i,
  input  logic             s_out_i,
  input  logic [AW-1:0]    nsfa_i,
  output logic [IW-1:0]    rd_idx_o,
  input  logic [AW-1:0]    rd_base_i,
  input  logic [CW-1:0]    rd_cnt_i,
  input  logic [OFS_W-1:0] rd_tail_i,
  output logic             wr_en_o,
  output logic             wr_clr_o,
  output logic [IW-1:0]    wr_idx_o,
  output logic [AW-1:0]    wr_base_o,
  output logic [CW-1:0]    wr_slot_o,
  output logic             wr_two_o,
  output logic [OFS_W-1:0] wr_ofs0_o,
  output logic [OFS_W-1:0] wr_ofs1_o,
  output logic             wr_spl_o,
  output logic [OFS_W-1:0] wr_tail_o
);
  localparam int EW = OFS_W + 1;
  localparam logic [EW-1:0] MAXO = EW'((1 << OFS_W) - 1);

  logic             last_vld_q;
  logic [IW-1:0]    last_idx_q, fifo_q;
  logic [AW-1:0]    last_nsfa_q;
  logic             app;
  logic [OFS_W-1:0] start;
  logic [CW-1:0]    cnt;
  logic [EW-1:0]    pend, send;

  assign rd_idx_o = last_idx_q;

  always_comb begin
    app = !hit_i && last_vld_q && pc_i == last_nsfa_q && int'(rd_cnt_i) < N
          && rd_base_i + AW'(rd_tail_i) == pc_i && !split_i
          && EW'(rd_tail_i) + EW'(len_p_i) <= MAXO;
    start     = hit_i ? htail_i : (app ? rd_tail_i : '0);
    cnt       = hit_i ? hcnt_i : (app ? rd_cnt_i : '0);
    pend      = EW'(start) + EW'(len_p_i);
    send      = pend + EW'(len_s_i);
    wr_en_o   = fetch_vld_i && p_out_i && pend <= MAXO;
    wr_clr_o  = !hit_i && !app;
    wr_idx_o  = hit_i ? hit_idx_i : (app ? last_idx_q : fifo_q);
    wr_base_o = pc_i;
    wr_slot_o = cnt;
    wr_two_o  = s_out_i && int'(cnt) + 1 < N && send <= MAXO;
    wr_ofs0_o = start;
    wr_ofs1_o = pend[OFS_W-1:0];
    wr_spl_o  = !hit_i && split_i;
    wr_tail_o = wr_two_o ? send[OFS_W-1:0] : pend[OFS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_vld_q  <= 1'b0;
      last_idx_q  <= '0;
      last_nsfa_q <= '0;
      fifo_q      <= '0;
    end else if (fetch_vld_i) begin
      last_vld_q  <= 1'b1;
      last_idx_q  <= wr_en_o ? wr_idx_o : hit_idx_i;
      last_nsfa_q <= nsfa_i;
      if (wr_en_o && wr_clr_o)
        fifo_q <= (int'(fifo_q) == DEPTH - 1) ? '0 : fifo_q + 1'b1;
    end
  end
endmodule

// File: rtl/ipt_ident.sv
module ipt_ident
  import ipt_pkg::*;
#(
  parameter int N     = 4,
  parameter int DEPTH = 64,
  parameter int AW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_vld_i,
  input  logic [AW-1:0]     fetch_pc_i,
  input  logic              split_i,
  input  logic [N-1:0]      taken_i,
  input  logic [LEN_W-1:0]  len_p_i,
  input  logic [LEN_W-1:0]  len_s_i,
  output logic              hit_o,
  output logic [N-1:0]      ptr_vld_o,
  output logic [N-1:0]      ptr_spl_o,
  output logic [N*AW-1:0]   ptr_o,
  output logic [AW-1:0]     nsfa_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(N + 1);

  logic                    lk_hit, p_out, s_out;
  logic [IW-1:0]           lk_idx, rd_idx, wr_idx;
  logic [AW-1:0]           lk_base, rd_base, wr_base;
  logic [N-1:0][OFS_W-1:0] lk_ofs;
  logic [N-1:0]            lk_spl;
  logic [CW-1:0]           lk_cnt, rd_cnt, wr_slot;
  logic [OFS_W-1:0]        lk_tail, rd_tail, wr_ofs0, wr_ofs1, wr_tail;
  logic                    wr_en, wr_clr, wr_two, wr_spl;
  logic [N-1:0][AW-1:0]    grp_ptr;

  ipt_table #(.N(N), .DEPTH(DEPTH), .AW(AW)) u_table (
    .clk_i, .rst_ni,
    .lk_pc_i(fetch_pc_i), .lk_hit_o(lk_hit), .lk_idx_o(lk_idx), .lk_base_o(lk_base),
    .lk_ofs_o(lk_ofs), .lk_spl_o(lk_spl), .lk_cnt_o(lk_cnt), .lk_tail_o(lk_tail),
    .rd_idx_i(rd_idx), .rd_base_o(rd_base), .rd_cnt_o(rd_cnt), .rd_tail_o(rd_tail),
    .wr_en_i(wr_en), .wr_clr_i(wr_clr), .wr_idx_i(wr_idx), .wr_base_i(wr_base),
    .wr_slot_i(wr_slot), .wr_two_i(wr_two), .wr_ofs0_i(wr_ofs0), .wr_ofs1_i(wr_ofs1),
    .wr_spl_i(wr_spl), .wr_tail_i(wr_tail)
  );

  ipt_group #(.N(N), .AW(AW)) u_group (
    .fetch_vld_i, .pc_i(fetch_pc_i), .split_i, .taken_i, .len_p_i, .len_s_i,
    .hit_i(lk_hit), .base_i(lk_base), .ofs_i(lk_ofs), .spl_i(lk_spl),
    .cnt_i(lk_cnt), .tail_i(lk_tail),
    .ptr_o(grp_ptr), .vld_o(ptr_vld_o), .spl_o(ptr_spl_o), .nsfa_o,
    .p_out_o(p_out), .s_out_o(s_out)
  );

  ipt_place #(.N(N), .DEPTH(DEPTH), .AW(AW)) u_place (
    .clk_i, .rst_ni, .fetch_vld_i, .pc_i(fetch_pc_i), .split_i, .len_p_i, .len_s_i,
    .hit_i(lk_hit), .hit_idx_i(lk_idx), .hcnt_i(lk_cnt), .htail_i(lk_tail),
    .p_out_i(p_out), .s_out_i(s_out), .nsfa_i(nsfa_o),
    .rd_idx_o(rd_idx), .rd_base_i(rd_base), .rd_cnt_i(rd_cnt), .rd_tail_i(rd_tail),
    .wr_en_o(wr_en), .wr_clr_o(wr_clr), .wr_idx_o(wr_idx), .wr_base_o(wr_base),
    .wr_slot_o(wr_slot), .wr_two_o(wr_two), .wr_ofs0_o(wr_ofs0), .wr_ofs1_o(wr_ofs1),
    .wr_spl_o(wr_spl), .wr_tail_o(wr_tail)
  );

  assign hit_o = fetch_vld_i & lk_hit;
  assign ptr_o = grp_ptr;
endmodule

// File: rtl/ipt_ident_chk.sv
module ipt_ident_chk #(
  parameter int N  = 4,
  parameter int AW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fetch_vld_i,
  input logic [AW-1:0]   fetch_pc_i,
  input logic [N-1:0]    taken_i,
  input logic            hit_o,
  input logic [N-1:0]    ptr_vld_o,
  input logic [N*AW-1:0] ptr_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_vld_i |-> (ptr_vld_o == '0 && !hit_o)); // R1

  AST_HIT_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (ptr_vld_o[0] && ptr_o[AW-1:0] == fetch_pc_i)); // R2

  AST_MISS_PROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_vld_i && !hit_o) |-> (ptr_vld_o[0] && ptr_o[AW-1:0] == fetch_pc_i)); // R3

  AST_MISS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_vld_i && !hit_o && ptr_vld_o[1]) |-> (ptr_o[2*AW-1:AW] == fetch_pc_i + AW'(3))); // R3

  AST_GROUP_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_vld_i |-> ((ptr_vld_o & N'(ptr_vld_o + 1'b1)) == '0)); // R6

  AST_TAKEN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_vld_i && taken_i[0]) |-> (ptr_vld_o == N'(1))); // R6
endmodule

bind ipt_ident ipt_ident_chk #(.N(N), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fetch_vld_i(fetch_vld_i), .fetch_pc_i(fetch_pc_i),
  .taken_i(taken_i), .hit_o(hit_o), .ptr_vld_o(ptr_vld_o), .ptr_o(ptr_o)
);

// File: tb/sim_ipt_ident.sv
module sim_ipt_ident;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int NV = 14;

  typedef struct packed {
    logic [31:0]      pc;
    logic             spl;
    logic [3:0]       tk;
    logic [3:0]       lp;
    logic [3:0]       ls;
    logic [3:0]       ev;
    logic [3:0][31:0] ep;
    logic [31:0]      en;
    logic             eh;
    logic [3:0]       es;
  } vec_t;

  // ep listed slot3..slot0
  localparam vec_t VEC [NV] = '{
    '{32'h100, 1'b0, 4'b0000, 4'd3, 4'd2,  4'b0011, '{32'h0, 32'h0, 32'h103, 32'h100}, 32'h105, 1'b0, 4'b0000},
    '{32'h105, 1'b0, 4'b0000, 4'd5, 4'd4,  4'b0001, '{32'h0, 32'h0, 32'h0, 32'h105},   32'h10A, 1'b0, 4'b0000},
    '{32'h100, 1'b0, 4'b0000, 4'd3, 4'd1,  4'b1111, '{32'h10A, 32'h105, 32'h103, 32'h100}, 32'h10D, 1'b1, 4'b0000},
    '{32'h100, 1'b0, 4'b0000, 4'd7, 4'd7,  4'b1111, '{32'h10A, 32'h105, 32'h103, 32'h100}, 32'h10D, 1'b1, 4'b0000},
    '{32'h10D, 1'b0, 4'b0000, 4'd3, 4'd3,  4'b0011, '{32'h0, 32'h0, 32'h110, 32'h10D}, 32'h113, 1'b0, 4'b0000},
    '{32'h100, 1'b0, 4'b0010, 4'd3, 4'd3,  4'b0011, '{32'h0, 32'h0, 32'h103, 32'h100}, 32'h105, 1'b1, 4'b0000},
    '{32'h200, 1'b1, 4'b0000, 4'd4, 4'd2,  4'b0001, '{32'h0, 32'h0, 32'h0, 32'h200},   32'h204, 1'b0, 4'b0001},
    '{32'h204, 1'b1, 4'b0000, 4'd3, 4'd3,  4'b0011, '{32'h0, 32'h0, 32'h207, 32'h204}, 32'h20A, 1'b0, 4'b0001},
    '{32'h204, 1'b0, 4'b0000, 4'd3, 4'd2,  4'b1111, '{32'h20D, 32'h20A, 32'h207, 32'h204}, 32'h20F, 1'b1, 4'b0001},
    '{32'h200, 1'b0, 4'b0000, 4'd3, 4'd3,  4'b0111, '{32'h0, 32'h207, 32'h204, 32'h200}, 32'h20A, 1'b1, 4'b0001},
    '{32'h300, 1'b0, 4'b0001, 4'd3, 4'd2,  4'b0001, '{32'h0, 32'h0, 32'h0, 32'h300},   32'h303, 1'b0, 4'b0000},
    '{32'h400, 1'b0, 4'b0000, 4'd3, 4'd15, 4'b0011, '{32'h0, 32'h0, 32'h403, 32'h400}, 32'h412, 1'b0, 4'b0000},
    '{32'h400, 1'b0, 4'b0000, 4'd2, 4'd1,  4'b0011, '{32'h0, 32'h0, 32'h403, 32'h400}, 32'h405, 1'b1, 4'b0000},
    '{32'h400, 1'b0, 4'b0000, 4'd3, 4'd4,  4'b1111, '{32'h408, 32'h405, 32'h403, 32'h400}, 32'h40C, 1'b1, 4'b0000}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fetch_vld = 1'b0;
  logic [AW-1:0]   fetch_pc = '0;
  logic            split = 1'b0;
  logic [N-1:0]    taken = '0;
  logic [3:0]      len_p = 4'd3;
  logic [3:0]      len_s = 4'd3;
  logic            hit;
  logic [N-1:0]    ptr_vld, ptr_spl;
  logic [N*AW-1:0] ptr;
  logic [AW-1:0]   nsfa;
  int              n_chk = 0;
  int              n_fail = 0;
  bit              done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipt_ident #(.N(N), .DEPTH(64), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fetch_vld_i(fetch_vld), .fetch_pc_i(fetch_pc),
    .split_i(split), .taken_i(taken), .len_p_i(len_p), .len_s_i(len_s),
    .hit_o(hit), .ptr_vld_o(ptr_vld), .ptr_spl_o(ptr_spl), .ptr_o(ptr), .nsfa_o(nsfa)
  );

  function automatic string tag_of(int i);
    case (i)
      0: return "R3";   1: return "R7";   2: return "R4";   3: return "R2";
      4: return "R8";   5: return "R6";   6: return "R13";  7: return "R9";
      8: return "R9";   9: return "R4";  10: return "R6";  11: return "R10";
      12: return "R10"; default: return "R4";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic v, logic [31:0] pc, logic sp, logic [3:0] tk,
                       logic [3:0] lp, logic [3:0] ls);
    @(negedge clk);
    fetch_vld = v; fetch_pc = pc; split = sp; taken = tk; len_p = lp; len_s = ls;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12 / R1: reset state with no fetch
    apply(1'b0, 32'h100, 1'b0, 4'b0, 4'd3, 4'd3);
    chk("R1", "idle vld", 32'(ptr_vld), 32'h0);
    chk("R12", "idle hit", 32'(hit), 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, VEC[i].pc, VEC[i].spl, VEC[i].tk, VEC[i].lp, VEC[i].ls);
      chk(tag_of(i), "hit", 32'(hit), 32'(VEC[i].eh));
      chk(tag_of(i), "vld", 32'(ptr_vld), 32'(VEC[i].ev));
      for (int k = 0; k < N; k++)
        if (VEC[i].ev[k]) chk(tag_of(i), "ptr", ptr[k*AW +: AW], VEC[i].ep[k]);
      chk("R5", "nsfa", nsfa, VEC[i].en);
      chk("R13", "spl", 32'(ptr_spl), 32'(VEC[i].es));
    end

    // R1: an idle cycle must not record its address
    apply(1'b0, 32'h700, 1'b0, 4'b0, 4'd3, 4'd3);
    chk("R1", "idle vld", 32'(ptr_vld), 32'h0);
    apply(1'b1, 32'h700, 1'b0, 4'b0, 4'd3, 4'd2);
    chk("R1", "no record", 32'(hit), 32'h0);

    // R11: fill the rest of the FIFO (entries 0..6 used, 57 left)
    for (int i = 0; i < 57; i++) begin
      apply(1'b1, 32'h1000 + 32'(i) * 32'h10, 1'b0, 4'b0, 4'd3, 4'd2);
      chk("R11", "fill miss", 32'(hit), 32'h0);
    end
    apply(1'b1, 32'h100, 1'b0, 4'b0, 4'd7, 4'd7);
    chk("R11", "oldest kept", 32'(hit), 32'h1);
    chk("R11", "oldest nsfa", nsfa, 32'h10D);
    apply(1'b1, 32'h5000, 1'b0, 4'b0, 4'd3, 4'd2);
    chk("R11", "wrap alloc", 32'(hit), 32'h0);
    apply(1'b1, 32'h10D, 1'b0, 4'b0, 4'd3, 4'd2);
    chk("R8", "second entry kept", 32'(hit), 32'h1);
    chk("R4", "second entry vld", 32'(ptr_vld), 32'hF);
    chk("R4", "second entry probe", ptr[2*AW +: AW], 32'h113);
    chk("R5", "second entry nsfa", nsfa, 32'h118);
    apply(1'b1, 32'h100, 1'b0, 4'b0, 4'd3, 4'd2);
    chk("R11", "oldest evicted", 32'(hit), 32'h0);

    // R12: reset clears recorded entries
    @(negedge clk) rst_n = 1'b0;
    fetch_vld = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    apply(1'b1, 32'h10D, 1'b0, 4'b0, 4'd3, 4'd2);
    chk("R12", "miss after reset", 32'(hit), 32'h0);
    chk("R12", "probe after reset", ptr[AW-1:0], 32'h10D);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule